// File: doc/BRIEF.md
# Genetic configuration search engine

This block searches for a good setting of an external piece of hardware by running a genetic algorithm over fixed-width configuration words. Each candidate word drives the hardware under test directly. The block presents one word at a time on its configuration port and raises a request. It then waits until the measuring logic outside returns a score with a one-cycle acknowledge. How the score is measured is the outside logic's concern.

A run begins with a `start` pulse, which latches the run settings. These are the population size, the number of survivors, the crossover and mutation thresholds, the score goal, the generation budget and the random seed. A random first population is built from an internal 16-bit shift-register generator, and every member is then scored. After each scored generation the block copies the best-scoring members unchanged into the next population. It fills the remaining slots with children bred from tournament-picked parents. The run ends when any score reaches the goal or the generation budget is used up. `done` then rises and the best word seen in the whole run is presented with its score.

Top module: `gen_search`

## Requirements
- R1: On `start` the generator state is loaded with `seed` (a zero seed loads 1). Each draw first steps the state as next = {s[14:0], s[15]^s[13]^s[12]^s[10]} and returns the new state. Member i of the first population is the low W bits of draw number i, counting from 0.
- R2: While scoring, `cfg_req` is high and `cfg_out` holds member i until a cycle with `fit_ack` high. That cycle stores `fit_score` for member i. Members are scored in index order 0 to P-1 in every generation.
- R3: `best_cfg`/`best_fit` take the first score of a run, and afterwards any score strictly greater than the stored one. They are cleared on `start`.
- R4: An acknowledged score greater than or equal to `fit_target` raises `done` on the next cycle, and no further request is made.
- R5: When the last member of generation g is scored (generations count from 0) and g+1 >= `gen_limit`, `done` rises on the next cycle. A limit of 0 therefore acts as 1.
- R6: Members 0 to E-1 of each new generation are copied unchanged from the previous one, in descending score order. Equal scores are ordered by lower index first.
- R7: Each remaining child k (E to P-1) uses six draws in order. Draws 1 and 2 give candidates (d[7:0]*P)>>8, and the higher-scoring one becomes parent A (a tie goes to the lower index). Draws 3 and 4 pick parent B the same way.
- R8: For draw 5, if d[7:0] < `xover_rate` then cut = (d[15:8]*W)>>8, and the child takes bits below cut from B and the rest from A. Otherwise the child is A.
- R9: For draw 6, if d[7:0] < `mut_rate` the child bit at (d[15:8]*W)>>8 is inverted.
- R10: `done` and the best outputs hold until the next `start`, which restarts the run with fresh settings.
- R11: Population size P is `pop_size` clamped to [2, POP_MAX]. E is `elite_cnt` clamped to at most P. With E = P no child is bred.
- R12: After reset `cfg_req`, `done`, `best_cfg` and `best_fit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; sampled while idle or finished |
| seed | input | 16 | Generator seed |
| pop_size | input | PW | Requested population size |
| elite_cnt | input | PW | Survivors copied per generation |
| xover_rate | input | 8 | Crossover threshold out of 256 |
| mut_rate | input | 8 | Mutation threshold out of 256 |
| fit_target | input | FW | Score goal that ends the run |
| gen_limit | input | GW | Generation budget |
| cfg_req | output | 1 | Candidate awaiting a score |
| cfg_out | output | W | Candidate configuration word |
| fit_ack | input | 1 | Score valid, one cycle |
| fit_score | input | FW | Score of the presented candidate |
| done | output | 1 | Run finished |
| best_cfg | output | W | Best word of the run |
| best_fit | output | FW | Score of best_cfg |

## Verification
The hardest situations to reach from the ports are orderings that depend on equal scores: the survivor ranking and the tournament ties. Other hard cases are a goal met partway through a generation and a run where every member survives. The bench scores each word by how many bits match a fixed pattern, so scores fall on only 17 values and ties are common in every generation. The acknowledge delay rotates through 0, 1 and 2 cycles. Separate runs use a zero goal, a zero generation budget, survivors equal to the population, a zero seed and an undersized population.

// File: rtl/ga_pkg.sv
// Shared definitions for the genetic search engine.
// Assumes the random source is 16 bits wide.
package ga_pkg;
    localparam int RND_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE, ST_INIT, ST_EVAL, ST_RANK, ST_BREED, ST_SWAP, ST_DONE
    } ga_state_e;

    // One step of the shift-register generator (taps 16,14,13,11).
    function automatic logic [RND_W-1:0] lfsr_step(input logic [RND_W-1:0] s);
        return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/ga_lfsr.sv
// Random source: a 16-bit shift register. `draw` is the next state,
// and it is taken whenever `adv` is high. Assumes load and adv are
// never needed in the same cycle (load wins).
module ga_lfsr
    import ga_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic [RND_W-1:0] seed,
    output logic [RND_W-1:0] draw
);
    logic [RND_W-1:0] state_q;

    assign draw = lfsr_step(state_q);

    // Seed on load (zero is replaced by 1), step on each draw.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= RND_W'(1);
        else if (load)    state_q <= (seed == '0) ? RND_W'(1) : seed;
        else if (adv)     state_q <= draw;
    end
endmodule

// File: rtl/ga_xover.sv
// Single-point crossover. When rnd[7:0] < rate, the bits below the cut
// come from pb and the rest from pa; otherwise the result is pa.
// The cut is (rnd[15:8]*W)>>8. Assumes W >= 2.
module ga_xover #(
    parameter int W  = 16,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0] pa,
    input  logic [W-1:0] pb,
    input  logic [15:0]  rnd,
    input  logic [7:0]   rate,
    output logic [W-1:0] child
);
    logic          apply;
    logic [CW-1:0] cut;

    assign apply = rnd[7:0] < rate;
    assign cut   = CW'((16'(rnd[15:8]) * 16'(W)) >> 8);

    // Per-bit source choice against the cut position.
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign child[b] = (apply && (cut > CW'(b))) ? pb[b] : pa[b];
    end
endmodule

// File: rtl/ga_mutate.sv
// Single-bit mutation. When rnd[7:0] < rate, the bit at
// (rnd[15:8]*W)>>8 is inverted. Assumes W >= 2.
module ga_mutate #(
    parameter int W  = 16,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0] din,
    input  logic [15:0]  rnd,
    input  logic [7:0]   rate,
    output logic [W-1:0] dout
);
    logic          apply;
    logic [CW-1:0] pos;

    assign apply = rnd[7:0] < rate;
    assign pos   = CW'((16'(rnd[15:8]) * 16'(W)) >> 8);

    // Invert only the chosen bit.
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign dout[b] = din[b] ^ (apply && (pos == CW'(b)));
    end
endmodule

// File: rtl/gen_search.sv
// Elitist genetic search over W-bit configuration words.
// Flow: seed the population -> score each member over a req/ack
// handshake -> rank the top E -> breed the rest -> swap -> score again.
// Assumes that the scorer acknowledges only while cfg_req is high, and
// that W <= 16 (members come from the 16-bit random draw).
module gen_search
    import ga_pkg::*;
#(
    parameter int W       = 16,
    parameter int POP_MAX = 100,
    parameter int FW      = 16,
    parameter int GW      = 16,
    localparam int PW     = $clog2(POP_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [15:0]   seed,
    input  logic [PW-1:0] pop_size,
    input  logic [PW-1:0] elite_cnt,
    input  logic [7:0]    xover_rate,
    input  logic [7:0]    mut_rate,
    input  logic [FW-1:0] fit_target,
    input  logic [GW-1:0] gen_limit,
    output logic          cfg_req,
    output logic [W-1:0]  cfg_out,
    input  logic          fit_ack,
    input  logic [FW-1:0] fit_score,
    output logic          done,
    output logic [W-1:0]  best_cfg,
    output logic [FW-1:0] best_fit
);
    ga_state_e           state_q;
    logic [W-1:0]        cur_q [POP_MAX];
    logic [W-1:0]        nxt_q [POP_MAX];
    logic [FW-1:0]       fit_q [POP_MAX];
    logic [POP_MAX-1:0]  taken_q;
    logic [PW-1:0]       pop_q, el_q, idx_q, k_q, bi_q, t_q;
    logic [PW-1:0]       pop_c, el_c, last_idx, last_el, pick_idx, win_idx, sel_idx;
    logic [7:0]          xr_q, mr_q;
    logic [FW-1:0]       tgt_q, best_fit_q, rank_fit_q;
    logic [W-1:0]        best_cfg_q, pa_q, pb_q, child_q, x_child, m_child;
    logic [GW-1:0]       gen_q, lim_q;
    logic [2:0]          step_q;
    logic                have_best_q, rank_have_q, cand, gen_done, lfsr_load, lfsr_adv;
    logic [15:0]         rnd;

    ga_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .load(lfsr_load), .adv(lfsr_adv),
                    .seed(seed), .draw(rnd));
    ga_xover #(.W(W)) u_xover (.pa(pa_q), .pb(pb_q), .rnd(rnd), .rate(xr_q),
                               .child(x_child));
    ga_mutate #(.W(W)) u_mutate (.din(child_q), .rnd(rnd), .rate(mr_q),
                                 .dout(m_child));

    assign lfsr_load = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign lfsr_adv  = (state_q == ST_INIT) || (state_q == ST_BREED);
    assign last_idx  = pop_q - PW'(1);
    assign last_el   = el_q - PW'(1);
    assign gen_done  = ({1'b0, gen_q} + (GW+1)'(1)) >= {1'b0, lim_q};
    assign pick_idx  = PW'((16'(rnd[7:0]) * 16'(pop_q)) >> 8);

    // Clamp the requested sizes to the legal range.
    always_comb begin
        pop_c = pop_size;
        if (pop_size < PW'(2))             pop_c = PW'(2);
        else if (pop_size > PW'(POP_MAX))  pop_c = PW'(POP_MAX);
        el_c = (elite_cnt > pop_c) ? pop_c : elite_cnt;
    end

    // Binary tournament between the held candidate and a fresh pick.
    always_comb begin
        if (fit_q[t_q] > fit_q[pick_idx])       win_idx = t_q;
        else if (fit_q[pick_idx] > fit_q[t_q])  win_idx = pick_idx;
        else                                    win_idx = (t_q < pick_idx) ? t_q : pick_idx;
    end

    // Ranking scan: first strictly better untaken member wins.
    assign cand    = !taken_q[idx_q] && (!rank_have_q || fit_q[idx_q] > rank_fit_q);
    assign sel_idx = cand ? idx_q : bi_q;

    // Sequencer for seeding, scoring, ranking, breeding and swapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;  idx_q <= '0;  k_q <= '0;  bi_q <= '0;  t_q <= '0;
            pop_q <= PW'(2);  el_q <= '0;  xr_q <= '0;  mr_q <= '0;
            tgt_q <= '0;  lim_q <= '0;  gen_q <= '0;  step_q <= '0;
            best_fit_q <= '0;  best_cfg_q <= '0;  have_best_q <= 1'b0;
            rank_have_q <= 1'b0;  rank_fit_q <= '0;  taken_q <= '0;
            pa_q <= '0;  pb_q <= '0;  child_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: if (start) begin
                    pop_q <= pop_c;  el_q <= el_c;  xr_q <= xover_rate;  mr_q <= mut_rate;
                    tgt_q <= fit_target;  lim_q <= gen_limit;  gen_q <= '0;  idx_q <= '0;
                    best_fit_q <= '0;  best_cfg_q <= '0;  have_best_q <= 1'b0;
                    state_q <= ST_INIT;
                end
                ST_INIT: begin
                    cur_q[idx_q] <= rnd[W-1:0];
                    if (idx_q == last_idx) begin idx_q <= '0; state_q <= ST_EVAL; end
                    else idx_q <= idx_q + PW'(1);
                end
                ST_EVAL: if (fit_ack) begin
                    fit_q[idx_q] <= fit_score;
                    if (!have_best_q || fit_score > best_fit_q) begin
                        best_fit_q <= fit_score;  best_cfg_q <= cur_q[idx_q];  have_best_q <= 1'b1;
                    end
                    if (fit_score >= tgt_q) state_q <= ST_DONE;
                    else if (idx_q == last_idx) begin
                        idx_q <= '0;  k_q <= '0;  step_q <= '0;
                        rank_have_q <= 1'b0;  taken_q <= '0;
                        if (gen_done)            state_q <= ST_DONE;
                        else if (el_q != '0)     state_q <= ST_RANK;
                        else                     state_q <= ST_BREED;
                    end else idx_q <= idx_q + PW'(1);
                end
                ST_RANK: begin
                    if (idx_q == last_idx) begin
                        nxt_q[k_q] <= cur_q[sel_idx];
                        taken_q[sel_idx] <= 1'b1;
                        idx_q <= '0;  rank_have_q <= 1'b0;  k_q <= k_q + PW'(1);
                        if (k_q == last_el) state_q <= (el_q == pop_q) ? ST_SWAP : ST_BREED;
                    end else begin
                        idx_q <= idx_q + PW'(1);
                        if (cand) begin bi_q <= idx_q; rank_fit_q <= fit_q[idx_q]; rank_have_q <= 1'b1; end
                    end
                end
                ST_BREED: begin
                    step_q <= step_q + 3'd1;
                    case (step_q)
                        3'd0:    t_q <= pick_idx;
                        3'd1:    pa_q <= cur_q[win_idx];
                        3'd2:    t_q <= pick_idx;
                        3'd3:    pb_q <= cur_q[win_idx];
                        3'd4:    child_q <= x_child;
                        default: begin
                            nxt_q[k_q] <= m_child;
                            step_q <= '0;
                            if (k_q == last_idx) state_q <= ST_SWAP;
                            else k_q <= k_q + PW'(1);
                        end
                    endcase
                end
                ST_SWAP: begin
                    for (int i = 0; i < POP_MAX; i++) cur_q[i] <= nxt_q[i];
                    gen_q <= gen_q + GW'(1);
                    idx_q <= '0;
                    state_q <= ST_EVAL;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cfg_req  = (state_q == ST_EVAL);
    assign cfg_out  = cur_q[idx_q];
    assign done     = (state_q == ST_DONE);
    assign best_cfg = best_cfg_q;
    assign best_fit = best_fit_q;
endmodule

// File: rtl/gen_search_chk.sv
// Protocol and result checks for gen_search, attached by bind.
// Assumes the latched score goal is visible as `tgt`.
module gen_search_chk #(
    parameter int W  = 16,
    parameter int FW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          cfg_req,
    input logic [W-1:0]  cfg_out,
    input logic          fit_ack,
    input logic [FW-1:0] fit_score,
    input logic          done,
    input logic [FW-1:0] best_fit,
    input logic [FW-1:0] tgt
);
    // R2
    hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !fit_ack) |=> (cfg_req && $stable(cfg_out)));

    // R2
    req_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !done);

    // R3
    best_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && fit_ack && fit_score > best_fit) |=> (best_fit == $past(fit_score)));

    // R4
    target_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && fit_ack && fit_score >= tgt) |=> (done && !cfg_req));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(best_fit)));
endmodule

bind gen_search gen_search_chk #(.W(W), .FW(FW)) u_gen_search_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_req(cfg_req), .cfg_out(cfg_out),
    .fit_ack(fit_ack), .fit_score(fit_score), .done(done), .best_fit(best_fit),
    .tgt(tgt_q)
);

// File: tb/gen_search_bench.sv
`timescale 1ns/1ps
// Behavioural reference for the genetic search engine. A model run
// predicts every word to be scored, and the bench compares cfg_out with
// it on each clock while a request is pending.
module gen_search_bench;
    localparam int W = 16, POP_MAX = 100, FW = 16, GW = 16, PW = 7;

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0, fit_ack = 1'b0;
    logic [15:0]   seed = '0;
    logic [PW-1:0] pop_size = '0, elite_cnt = '0;
    logic [7:0]    xover_rate = '0, mut_rate = '0;
    logic [FW-1:0] fit_target = '0, fit_score = '0;
    logic [GW-1:0] gen_limit = '0;
    logic          cfg_req, done;
    logic [W-1:0]  cfg_out, best_cfg;
    logic [FW-1:0] best_fit;

    int n_vec = 0, n_bad = 0;
    logic [15:0] exp_cfg[$];
    string       exp_tag[$];
    logic [15:0] exp_bcfg;
    int          exp_bfit;
    bit          exp_hit;

    always #2.5 clk = ~clk;

    gen_search u_gen_search (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .pop_size(pop_size),
        .elite_cnt(elite_cnt), .xover_rate(xover_rate), .mut_rate(mut_rate),
        .fit_target(fit_target), .gen_limit(gen_limit), .cfg_req(cfg_req),
        .cfg_out(cfg_out), .fit_ack(fit_ack), .fit_score(fit_score), .done(done),
        .best_cfg(best_cfg), .best_fit(best_fit)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int score_of(input logic [15:0] c);
        return $countones(~(c ^ 16'hA5C3));
    endfunction

    function automatic logic [15:0] step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // Reference run: predicts the scored words and the final best.
    task automatic build_model(input int p, input int e, input int xr, input int mr,
                               input int tgt, input int lim, input logic [15:0] sd);
        logic [15:0] cur[POP_MAX], nxt[POP_MAX];
        int          fit[POP_MAX];
        bit          taken[POP_MAX];
        logic [15:0] st, a, b, ch;
        int pop, el, idx[4], w[2];
        bit have, stop;
        pop = (p < 2) ? 2 : ((p > POP_MAX) ? POP_MAX : p);
        el  = (e > pop) ? pop : e;
        st  = (sd == 0) ? 16'h1 : sd;
        exp_cfg.delete(); exp_tag.delete();
        for (int i = 0; i < pop; i++) begin st = step(st); cur[i] = st; end
        have = 0; stop = 0; exp_bfit = 0; exp_bcfg = '0; exp_hit = 0;
        for (int g = 0; !stop; g++) begin
            for (int i = 0; i < pop; i++) begin
                exp_cfg.push_back(cur[i]);
                if (g == 0)      exp_tag.push_back("R2 R1 initial member");
                else if (i < el) exp_tag.push_back("R2 R6 survivor");
                else             exp_tag.push_back("R2 R7 R8 R9 bred child");
                fit[i] = score_of(cur[i]);
                if (!have || fit[i] > exp_bfit) begin exp_bfit = fit[i]; exp_bcfg = cur[i]; have = 1; end
                if (fit[i] >= tgt) begin stop = 1; exp_hit = 1; break; end
            end
            if (stop || g + 1 >= lim) break;
            for (int i = 0; i < pop; i++) taken[i] = 0;
            for (int k = 0; k < el; k++) begin
                int bi = -1;
                for (int j = 0; j < pop; j++)
                    if (!taken[j] && (bi < 0 || fit[j] > fit[bi])) bi = j;
                nxt[k] = cur[bi]; taken[bi] = 1;
            end
            for (int k = el; k < pop; k++) begin
                for (int q = 0; q < 4; q++) begin st = step(st); idx[q] = (int'(st[7:0]) * pop) >> 8; end
                for (int q = 0; q < 2; q++) begin
                    int x = idx[2*q], y = idx[2*q+1];
                    if (fit[x] > fit[y])      w[q] = x;
                    else if (fit[y] > fit[x]) w[q] = y;
                    else                      w[q] = (x < y) ? x : y;
                end
                a = cur[w[0]]; b = cur[w[1]]; ch = a;
                st = step(st);
                if (int'(st[7:0]) < xr) begin
                    int cut = (int'(st[15:8]) * W) >> 8;
                    logic [15:0] m = (16'h1 << cut) - 16'h1;
                    ch = (a & ~m) | (b & m);
                end
                st = step(st);
                if (int'(st[7:0]) < mr) ch[(int'(st[15:8]) * W) >> 8] = ~ch[(int'(st[15:8]) * W) >> 8];
                nxt[k] = ch;
            end
            for (int i = 0; i < pop; i++) cur[i] = nxt[i];
        end
    endtask

    // Drive one run and act as the scoring hardware.
    task automatic run_case(input int p, input int e, input int xr, input int mr,
                            input int tgt, input int lim, input logic [15:0] sd);
        int n_neg = 0, ack_neg = -10, dly = 0, wt = 0;
        bit fin = 0;
        string stop_tag;
        build_model(p, e, xr, mr, tgt, lim, sd);
        stop_tag = exp_hit ? "R4 goal stop" : "R5 generation budget stop";
        pop_size = PW'(p); elite_cnt = PW'(e); xover_rate = 8'(xr); mut_rate = 8'(mr);
        fit_target = FW'(tgt); gen_limit = GW'(lim); seed = sd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done, "R10 start clears done", done, 0);
        while (!fin) begin
            @(negedge clk);
            n_neg++;
            fit_ack = 1'b0;
            if (done) begin
                check(ack_neg == n_neg - 1, {stop_tag, " timing"}, n_neg - ack_neg, 1);
                check(exp_cfg.size() == 0, {stop_tag, " words left"}, exp_cfg.size(), 0);
                check(best_cfg == exp_bcfg, "R3 best word", best_cfg, exp_bcfg);
                check(int'(best_fit) == exp_bfit, "R3 best score", best_fit, exp_bfit);
                fin = 1;
            end else if (cfg_req) begin
                if (exp_cfg.size() == 0) begin
                    check(0, "R2 request past predicted end", cfg_out, 0);
                    fin = 1;
                end else begin
                    check(cfg_out == exp_cfg[0], exp_tag[0], cfg_out, exp_cfg[0]);
                    if (wt >= dly) begin
                        fit_ack = 1'b1;
                        fit_score = FW'(score_of(cfg_out));
                        void'(exp_cfg.pop_front());
                        void'(exp_tag.pop_front());
                        ack_neg = n_neg; wt = 0; dly = (dly + 1) % 3;
                    end else wt++;
                end
            end
        end
        repeat (4) @(negedge clk);
        check(done && !cfg_req, "R10 done held", {cfg_req, done}, 1);
        check(int'(best_fit) == exp_bfit && best_cfg == exp_bcfg, "R10 result held", best_fit, exp_bfit);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!cfg_req && !done, "R12 reset handshake idle", {cfg_req, done}, 0);
        check(best_cfg == '0 && best_fit == '0, "R12 reset best cleared", best_fit, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_case(20, 2, 179, 10, 100, 4, 16'hACE1);   // budget end, small survivor set
        run_case(100, 9, 179, 10, 100, 2, 16'h1234);  // full-size population
        run_case(16, 3, 179, 10, 12, 50, 16'h5A5A);   // goal probably met mid-run
        run_case(6, 6, 0, 255, 100, 3, 16'h0F0F);     // R11 every member survives
        run_case(10, 0, 255, 0, 100, 3, 16'h0000);    // R1 zero seed, no survivors
        run_case(1, 5, 128, 128, 100, 2, 16'hBEEF);   // R11 clamped sizes
        run_case(12, 4, 179, 10, 0, 5, 16'h7777);     // R4 goal met at first score
        run_case(8, 2, 179, 10, 100, 0, 16'h3C3C);    // R5 zero budget acts as one
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule